// File: doc/BRIEF.md
# Pulse-Count Level Register Interface

This block takes one asynchronous control pin and turns the number of rising edges in each burst into register writes. A burst is over when the pin stays high for a latch timeout. The block then classifies the count. A count in the data range loads a 5-bit level into one or both level registers. A small set of counts just above the data range selects which register later data bursts reach.

If the pin stays low past a longer shutdown timeout, the block clears the address and both levels and drops its enabled flag. The first rising edge after that raises the flag again. Both timeouts are given in system clock cycles.

A host writes a level by sending an address burst followed by one or more data bursts. With no address burst at all, a data burst reaches both registers.

Top module: `pulse_reg_if`

## Requirements
- R1: A latched count n with 1 <= n <= 32 writes the code n-1 to every register the current address targets, so 1 gives 0 and 32 gives 31.
- R2: A latched count of 33, 34 or 35 selects address 0, 1 or 2 respectively and leaves both level outputs unchanged.
- R3: A count is latched only after the synchronized pin has stayed high for LATCH_CYC cycles following its last rising edge. Shorter high gaps continue the same burst, and the outputs keep their old values until the latch.
- R4: Address 0 targets both registers. Address 1 targets only `lvl_a_o`, the level for outputs 1 to 3. Address 2 targets only `lvl_b_o`, the level for output 4.
- R5: After reset or shutdown the address is 0, so a data burst sent with no address burst loads the same code into both registers.
- R6: The address stays in effect until another address burst or shutdown, so consecutive data bursts reach the same target.
- R7: Holding the pin low for SHUT_CYC cycles clears both levels and the address and drops `en_o`. Lows shorter than that change nothing.
- R8: A latched count above 35 changes neither level nor the address.
- R9: The edge counter saturates and does not wrap. A burst of 70 edges is discarded rather than decoded as 70 mod 64.
- R10: `en_o` rises one cycle after the first rising edge detected after reset or shutdown.
- R11: While reset is active and just after its release, both levels are 0 and `en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous pulse-count control pin |
| lvl_a_o | output | 5 | Level code for outputs 1 to 3 |
| lvl_b_o | output | 5 | Level code for output 4 |
| en_o | output | 1 | Enabled flag |

## Verification
Some checks run on every cycle as properties:
- Levels and address change only in the cycle after a latch or a shutdown.
- A shutdown leaves everything at zero.
- Out-of-range counts leave state untouched.
- The counter holds at saturation.
- A rising edge raises the enable.

Other behaviour can only be shown by the bench scenarios:
- The mapping from count to code.
- The mapping from address to target.
- Address persistence across bursts.
- The latch point in the middle of a burst.
- The near-miss shutdown.
- Saturation against wrap on a 70-edge burst.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  typedef enum logic [1:0] {
    TGT_BOTH = 2'd0,
    TGT_A    = 2'd1,
    TGT_B    = 2'd2
  } tgt_e;
endpackage

// File: rtl/pcr_sync.sv
module pcr_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic line_o,
  output logic rise_o
);
  logic [1:0] sync_q;
  logic       line_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      line_d_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], pin_i};
      line_d_q <= sync_q[1];
    end
  end

  assign line_o = sync_q[1];
  assign rise_o = sync_q[1] & ~line_d_q;
endmodule

// File: rtl/pcr_timer.sv
module pcr_timer #(
  parameter int unsigned LATCH_CYC = 16,
  parameter int unsigned SHUT_CYC  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic rise_i,
  output logic latch_o,
  output logic shut_o
);
  localparam int unsigned HW = $clog2(LATCH_CYC + 1);
  localparam int unsigned LW = $clog2(SHUT_CYC + 1);
  localparam logic [HW-1:0] HI_END = HW'(LATCH_CYC);
  localparam logic [LW-1:0] LO_END = LW'(SHUT_CYC);

  logic [HW-1:0] hi_q;
  logic [LW-1:0] lo_q;

  // latch fires on the cycle the high run reaches LATCH_CYC
  assign latch_o = line_i && !rise_i && (hi_q == HI_END - HW'(1));
  assign shut_o  = !line_i && (lo_q == LO_END - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (!line_i)                             hi_q <= '0;
      else if (rise_i)                         hi_q <= HW'(1);
      else if (hi_q != '0 && hi_q < HI_END)    hi_q <= hi_q + HW'(1);

      if (line_i)                              lo_q <= '0;
      else if (lo_q < LO_END)                  lo_q <= lo_q + LW'(1);
    end
  end

  AST_LATCH_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o); // R3
  AST_SHUT_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_o |=> !shut_o); // R7
endmodule

// File: rtl/pcr_regs.sv
module pcr_regs
  import pcr_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             latch_i,
  input  logic             shut_i,
  output logic [LVL_W-1:0] lvl_a_o,
  output logic [LVL_W-1:0] lvl_b_o,
  output logic             en_o
);
  localparam int unsigned   NREG     = 2;
  localparam int unsigned   DATA_N   = 2 ** LVL_W;
  localparam int unsigned   CNT_W    = $clog2(DATA_N + 4);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] DATA_MAX = CNT_W'(DATA_N);
  localparam logic [CNT_W-1:0] ADDR_LO  = CNT_W'(DATA_N + 1);
  localparam logic [CNT_W-1:0] ADDR_HI  = CNT_W'(DATA_N + 3);

  logic [CNT_W-1:0] cnt_q;
  tgt_e             addr_q;
  logic             en_q;
  logic [LVL_W-1:0] lvl_q [NREG];
  logic             is_data, is_addr;
  logic [LVL_W-1:0] code;

  assign is_data = (cnt_q != '0) && (cnt_q <= DATA_MAX);
  assign is_addr = (cnt_q >= ADDR_LO) && (cnt_q <= ADDR_HI);
  assign code    = LVL_W'(cnt_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= TGT_BOTH;
      en_q   <= 1'b0;
    end else if (shut_i) begin
      cnt_q  <= '0;
      addr_q <= TGT_BOTH;
      en_q   <= 1'b0;
    end else begin
      if (latch_i) begin
        cnt_q <= '0;
        if (is_addr) addr_q <= tgt_e'(2'(cnt_q - ADDR_LO));
      end else if (rise_i && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (rise_i) en_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_lvl
    logic wr;
    assign wr = latch_i && is_data &&
                (addr_q == TGT_BOTH || addr_q == tgt_e'(2'(g + 1)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lvl_q[g] <= '0;
      else if (shut_i) lvl_q[g] <= '0;
      else if (wr)     lvl_q[g] <= code;
    end
  end

  assign lvl_a_o = lvl_q[0];
  assign lvl_b_o = lvl_q[1];
  assign en_o    = en_q;

  AST_SHUT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_i |=> (lvl_a_o == '0 && lvl_b_o == '0 && addr_q == TGT_BOTH && !en_o)); // R7
  AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_i && !shut_i) |=> ($stable(lvl_a_o) && $stable(lvl_b_o))); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_i && !shut_i) |=> $stable(addr_q)); // R6
  AST_ADDR_NO_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && is_addr) |=> ($stable(lvl_a_o) && $stable(lvl_b_o))); // R2
  AST_BIG_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && cnt_q > ADDR_HI) |=> ($stable(lvl_a_o) && $stable(lvl_b_o) && $stable(addr_q))); // R8
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !latch_i && !shut_i) |=> cnt_q == CNT_MAX); // R9
  AST_EN_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> en_o); // R10
endmodule

// File: rtl/pulse_reg_if.sv
module pulse_reg_if #(
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned LATCH_CYC = 16,
  parameter int unsigned SHUT_CYC  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  output logic [LVL_W-1:0] lvl_a_o,
  output logic [LVL_W-1:0] lvl_b_o,
  output logic             en_o
);
  logic line, rise, latch, shut;

  pcr_sync i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .line_o(line),
    .rise_o(rise)
  );

  pcr_timer #(.LATCH_CYC(LATCH_CYC), .SHUT_CYC(SHUT_CYC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line),
    .rise_i (rise),
    .latch_o(latch),
    .shut_o (shut)
  );

  pcr_regs #(.LVL_W(LVL_W)) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .latch_i(latch),
    .shut_i (shut),
    .lvl_a_o(lvl_a_o),
    .lvl_b_o(lvl_b_o),
    .en_o   (en_o)
  );

  AST_RST_STATE: assert property (@(posedge clk_i)
    !rst_ni |=> (lvl_a_o == '0 && lvl_b_o == '0 && !en_o)); // R11
endmodule

// File: tb/test_pulse_reg_if.sv
`timescale 1ns/1ps
module test_pulse_reg_if;
  localparam int LATCH = 16;
  localparam int SHUT  = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic [4:0] lvl_a, lvl_b;
  logic       en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int exp_a = 0, exp_b = 0, exp_addr = 0, exp_en = 0;

  always #5 clk = ~clk;

  pulse_reg_if #(.LVL_W(5), .LATCH_CYC(LATCH), .SHUT_CYC(SHUT)) i_pulse_reg_if (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pin_i  (pin),
    .lvl_a_o(lvl_a),
    .lvl_b_o(lvl_b),
    .en_o   (en)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " lvl_a"}, int'(lvl_a), exp_a);
    check({req, " lvl_b"}, int'(lvl_b), exp_b);
    check({req, " en"}, int'(en), exp_en);
  endtask

  // reference model of a latched count
  task automatic model_apply(input int n);
    exp_en = 1;
    if (n >= 1 && n <= 32) begin
      if (exp_addr != 2) exp_a = n - 1;
      if (exp_addr != 1) exp_b = n - 1;
    end else if (n >= 33 && n <= 35) begin
      exp_addr = n - 33;
    end
  endtask

  task automatic model_shut();
    exp_a = 0; exp_b = 0; exp_addr = 0; exp_en = 0;
  endtask

  task automatic burst(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      pin = 1'b0;
      cyc(2 + int'($urandom_range(0, 3)));
      pin = 1'b1;
      if (i < n - 1) cyc(2 + int'($urandom_range(0, LATCH - 6)));
    end
    cyc(LATCH - 4);
    // R3: not latched yet, outputs keep old values
    check({"R3 prelatch ", req, " lvl_a"}, int'(lvl_a), exp_a);
    check({"R3 prelatch ", req, " lvl_b"}, int'(lvl_b), exp_b);
    cyc(10);
    model_apply(n);
    check_all(req);
  endtask

  task automatic shutdown();
    pin = 1'b0;
    cyc(SHUT + 6);
    model_shut();
    check_all("R7 shutdown");
  endtask

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    check_all("R11 in reset");
    rst_n = 1'b1;
    cyc(2);
    check_all("R11 after reset");

    burst(7, "R5 R1 R10 default both");
    burst(34, "R2 addr1");
    burst(20, "R4 addr1 to lvl_a");
    burst(1, "R6 R1 min code");
    burst(35, "R2 addr2");
    burst(32, "R4 R1 max to lvl_b");
    burst(3, "R6 addr2 kept");
    burst(33, "R2 addr0");
    burst(12, "R4 addr0 both");
    burst(36, "R8 count 36 discarded");
    burst(70, "R9 saturate no wrap");

    pin = 1'b0;
    cyc(SHUT - 10);
    check("R7 short low keeps en", int'(en), 1);
    check("R7 short low keeps lvl_a", int'(lvl_a), exp_a);
    pin = 1'b1;
    cyc(4);
    pin = 1'b0;
    cyc(SHUT + 6);
    model_shut();
    check_all("R7 shutdown");

    pin = 1'b1;
    cyc(4);
    check("R10 en after first rise", int'(en), 1);
    exp_en = 1;
    cyc(LATCH + 6);
    model_apply(1);
    burst(34, "R2 addr1 after shutdown");
    shutdown();
    burst(9, "R5 both after shutdown");

    for (int k = 0; k < 30; k++) begin
      int n;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 5)       n = 1 + int'($urandom_range(0, 31));
      else if (sel < 8)  n = 33 + int'($urandom_range(0, 2));
      else if (sel < 9)  n = 36 + int'($urandom_range(0, 4));
      else               n = 0;
      if (n == 0) shutdown();
      else        burst(n, "R1 R4 R6 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule